// File: doc/BRIEF.md
# Survivor History Store with Parent Pointers

This block keeps the decoded-bit history of every live path in a Viterbi decoder that retains only a limited, varying number of survivors per trellis stage. It holds `ROWS` history rows of `HIST_LEN` bits each, plus one occupancy flag per row. Because survivors are not pinned to fixed trellis states, a row is not tied to a state. On every stage strobe, each new survivor names the row its parent path lived in and supplies the decision bit of the branch it took. The block then rebuilds every row at once: it copies the parent's history, shifts it by one position, and appends the new bit.

The history length defaults to five times the code's constraint length. Once that many stages have been written since reset, each stage strobe yields one decoded bit. That bit is the oldest bit held in the row the caller marks as the lowest-cost path, and it comes with a one-cycle valid strobe.

Top module: `surv_mem`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `bit_out_vld` is 0. Reset also marks every row unoccupied, clears all histories and clears the stage count.
- R2: On a clock edge with `stage_en` high, row i with `surv_vld[i]`=1 is loaded with its parent row's history shifted one position toward the old end. The parent row is `parent_ptr[i*PW +: PW]`. `dec_bits[i]` goes in at bit 0 (the newest end), and bit `HIST_LEN-1` holds the oldest bit.
- R3: All rows are rebuilt at the same edge from the contents held before that edge. This holds when rows exchange parents, duplicate one parent, or shift in a ring.
- R4: On a stage strobe, a row with `surv_vld[i]`=0 becomes unoccupied and its history is cleared to all zeros. A later survivor that names it as parent inherits zeros.
- R5: In cycles with `stage_en` low, no history, occupancy flag or stage count changes, whatever the other inputs do. `bit_out_vld` stays 0 and `bit_out` holds its value.
- R6: `bit_out_vld` pulses for one cycle, on the cycle after a stage strobe. It does so only if that strobe is at least the `HIST_LEN`-th since reset.
- R7: With `bit_out_vld` high, `bit_out` equals bit `HIST_LEN-1` of the rebuilt row `best_row`. That is the decision appended `HIST_LEN-1` stages earlier along that path.
- R8: The stage count saturates at `HIST_LEN`, so decoded bits keep coming on every qualifying strobe for as long as stages arrive.
- R9: If `best_row` names a row whose `surv_vld` bit is 0 on that strobe, no decoded bit is issued (`bit_out_vld` stays 0). The stage still counts toward the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_en | input | 1 | One trellis stage is applied on this edge |
| surv_vld | input | ROWS | Bit i set: new row i carries a survivor this stage |
| parent_ptr | input | ROWS*PW | Field i: row holding the parent of new row i; a value of ROWS or more reads as an all-zero history |
| dec_bits | input | ROWS | Decision bit appended to new row i |
| best_row | input | PW | Row of the minimum-metric survivor this stage |
| bit_out | output | 1 | Oldest history bit of the selected row |
| bit_out_vld | output | 1 | One-cycle strobe qualifying `bit_out` |

## Verification
The bench builds the block with four rows and a constraint length of 2, which gives a ten-bit history. With that size, the fill boundary is reached within ten stages, and all 256 parent-pointer maps of the four rows can be swept in turn. Rotation, swap, duplicated-parent and cleared-row patterns then run through the full history depth many times over. The bench's reference keeps wider, untruncated path histories and reads the expected oldest bit arithmetically. The sweep also covers the saturated counter, unoccupied best rows and a second reset mid-run.

// File: rtl/surv_mem.sv
module surv_mem #(
  parameter int ROWS       = 8,
  parameter int CONSTR_LEN = 7,
  parameter int HIST_LEN   = 5 * CONSTR_LEN,
  localparam int PW        = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW        = $clog2(HIST_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stage_en,
  input  logic [ROWS-1:0]    surv_vld,
  input  logic [ROWS*PW-1:0] parent_ptr,
  input  logic [ROWS-1:0]    dec_bits,
  input  logic [PW-1:0]      best_row,
  output logic               bit_out,
  output logic               bit_out_vld
);

  logic [HIST_LEN-1:0] hist [ROWS];
  logic [HIST_LEN-1:0] nxt  [ROWS];
  logic [ROWS-1:0]     row_vld;
  logic [CW-1:0]       fill;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [PW-1:0]       ptr;
    logic [HIST_LEN-1:0] src;
    assign ptr = parent_ptr[g*PW +: PW];
    assign src = (32'(ptr) < ROWS) ? hist[ptr] : '0;
    assign nxt[g] = surv_vld[g] ? {src[HIST_LEN-2:0], dec_bits[g]} : '0;
  end

  logic best_ok, full;
  assign best_ok = (32'(best_row) < ROWS) && surv_vld[best_row];
  assign full    = fill >= CW'(HIST_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) hist[i] <= '0;
      row_vld     <= '0;
      fill        <= '0;
      bit_out     <= 1'b0;
      bit_out_vld <= 1'b0;
    end else begin
      bit_out_vld <= 1'b0;
      if (stage_en) begin
        for (int i = 0; i < ROWS; i++) hist[i] <= nxt[i];
        row_vld <= surv_vld;
        if (fill != CW'(HIST_LEN)) fill <= fill + 1'b1;
        if (best_ok && full) begin
          bit_out_vld <= 1'b1;
          bit_out     <= nxt[best_row][HIST_LEN-1];
        end
      end
    end
  end

endmodule

// File: rtl/surv_mem_chk.sv
module surv_mem_chk #(
  parameter int ROWS     = 8,
  parameter int HIST_LEN = 35,
  parameter int PW       = 3,
  parameter int CW       = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stage_en,
  input logic [ROWS-1:0]     surv_vld,
  input logic [ROWS-1:0]     dec_bits,
  input logic [PW-1:0]       best_row,
  input logic                bit_out,
  input logic                bit_out_vld,
  input logic [ROWS-1:0]     row_vld,
  input logic [CW-1:0]       fill,
  input logic [HIST_LEN-1:0] row0
);

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !bit_out_vld); // R1

  AST_NEWEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stage_en && surv_vld[0]) |-> row0[0] == $past(dec_bits[0])); // R2

  AST_CLEARED_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stage_en && !surv_vld[0]) |-> row0 == '0); // R4

  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stage_en) |-> row_vld == $past(surv_vld)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stage_en) |-> ($stable(row_vld) && $stable(fill) && $stable(row0) && $stable(bit_out) && !bit_out_vld)); // R5

  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_out_vld |-> $past(stage_en)); // R6

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_out_vld |-> $past(fill) >= CW'(HIST_LEN - 1)); // R6

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(HIST_LEN)); // R8

  AST_BEST_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_out_vld |-> $past(surv_vld[best_row])); // R9

endmodule

bind surv_mem surv_mem_chk #(.ROWS(ROWS), .HIST_LEN(HIST_LEN), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .surv_vld(surv_vld),
  .dec_bits(dec_bits), .best_row(best_row), .bit_out(bit_out),
  .bit_out_vld(bit_out_vld), .row_vld(row_vld), .fill(fill), .row0(hist[0])
);

// File: tb/surv_mem_test.sv
`timescale 1ns/1ps
module surv_mem_test;
  localparam int ROWS = 4;
  localparam int K    = 2;
  localparam int HL   = 5 * K;
  localparam int PW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stage_en = 1'b0;
  logic [ROWS-1:0] surv_vld = '0;
  logic [ROWS*PW-1:0] parent_ptr = '0;
  logic [ROWS-1:0] dec_bits = '0;
  logic [PW-1:0] best_row = '0;
  logic bit_out, bit_out_vld;

  int checks = 0;
  int fails = 0;
  logic [31:0] mh [ROWS];
  int nst = 0;

  always #2.5 clk = ~clk;

  surv_mem #(.ROWS(ROWS), .CONSTR_LEN(K)) uut (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .surv_vld(surv_vld),
    .parent_ptr(parent_ptr), .dec_bits(dec_bits), .best_row(best_row),
    .bit_out(bit_out), .bit_out_vld(bit_out_vld)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (stage %0d)", tag, act, exp, nst);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    stage_en = 1'b0;
    for (int i = 0; i < ROWS; i++) mh[i] = '0;
    nst = 0;
    @(negedge clk);
    check("R1", bit_out_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", bit_out_vld, 1'b0);
  endtask

  task automatic stage(input string tag, input logic [ROWS-1:0] v,
                       input logic [ROWS*PW-1:0] par, input logic [ROWS-1:0] d,
                       input logic [PW-1:0] b);
    logic [31:0] nh [ROWS];
    logic ev, eb;
    surv_vld = v; parent_ptr = par; dec_bits = d; best_row = b; stage_en = 1'b1;
    for (int i = 0; i < ROWS; i++)
      nh[i] = v[i] ? {mh[par[i*PW +: PW]][30:0], d[i]} : 32'd0;
    for (int i = 0; i < ROWS; i++) mh[i] = nh[i];
    nst++;
    ev = v[b] && (nst >= HL);
    eb = nh[b][HL-1];
    @(negedge clk);
    stage_en = 1'b0;
    check(tag, bit_out_vld, ev);
    if (ev) check(tag, bit_out, eb);
  endtask

  localparam logic [7:0] IDENT = 8'b11_10_01_00;
  localparam logic [7:0] ROT   = 8'b10_01_00_11;
  localparam logic [7:0] SWAP  = 8'b10_11_00_01;

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic held;
    for (int i = 0; i < ROWS; i++) mh[i] = '0;
    @(negedge clk);
    check("R1", bit_out_vld, 1'b0);
    do_reset();

    // fill: R2 identity pointers, R6 boundary at stage HL
    for (int s = 0; s < HL + 3; s++)
      stage((s < HL) ? "R6" : "R2", 4'hF, IDENT, 4'(s ^ (s >> 1)), 2'(s));

    // idle cycles with noisy inputs: R5
    held = bit_out;
    for (int c = 0; c < 6; c++) begin
      surv_vld = 4'(c * 5); parent_ptr = 8'(c * 37); dec_bits = 4'(~c); best_row = 2'(c);
      @(negedge clk);
      check("R5", bit_out_vld, 1'b0);
      check("R5", bit_out, held);
    end
    stage("R5", 4'hF, IDENT, 4'hA, 2'd1);

    // simultaneous rebuild: R3
    for (int s = 0; s < 2 * HL; s++)
      stage("R3", 4'hF, (s % 3 == 0) ? SWAP : ROT, 4'(s * 7), 2'(s >> 1));
    for (int s = 0; s < HL; s++)
      stage("R3", 4'hF, 8'b00_00_00_00, 4'(s * 3), 2'(s));

    // cleared rows used later as parents: R4
    stage("R4", 4'b0101, IDENT, 4'hF, 2'd0);
    for (int s = 0; s < HL + 2; s++)
      stage("R4", 4'hF, ROT, 4'hF, 2'd1);

    // best row unoccupied: R9
    stage("R9", 4'b1011, IDENT, 4'h5, 2'd2);
    stage("R9", 4'b0111, ROT, 4'h3, 2'd3);
    stage("R9", 4'hF, IDENT, 4'h9, 2'd3);

    // sweep of every parent map, saturated count: R7 and R8
    for (int m = 0; m < 256; m++)
      stage((m % 2) ? "R7" : "R8", (m % 5 == 0) ? 4'(~m) : 4'hF, 8'(m),
            4'(m ^ (m >> 3) ^ (m >> 5)), 2'(m >> 2));

    // second reset restarts the fill: R1, R6
    do_reset();
    for (int s = 0; s < HL + 1; s++)
      stage("R6", 4'hF, ROT, 4'(s + 9), 2'(s));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule